// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O controller that sits behind a small register port with one-cycle access. It holds an output latch and a direction register, and it passes the pin levels through a two-flop synchronizer so that software can read them. The number of pins equals the register width, which can be 8, 16, 32 or 64. The block drives a level and an output enable for each pin, so it can feed tristate pads directly.

Build-time parameters select the variant. The output latch can be written in one of three ways: through the data register only, through a set register and a clear register that act on single bits, or through one plain output register at the set offset. The direction register can be left out, can use 1 to mean output, or can use 1 to mean input. The numbering of pins to register bits can be normal or reversed. Two configurations stop elaboration: a width outside the four legal values, and both direction polarities selected at once.

Word offsets: 0 is the data register, 1 is the set register (or the plain output register), 2 is the clear register, 3 is the direction register. Offsets 4 to 7 are not mapped.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output latch is zero and every pin is an input (pin_oe all zero). The direction register reads as all zeros with the 1-means-output polarity and as all ones with the 1-means-input polarity.
- R2: A read of offset 0 returns the pin levels through a two-flop synchronizer. A level applied before a rising edge first shows up in the read value after the second rising edge.
- R3: In set/clear mode, writing offset 1 sets every latch bit that is 1 in the write data, and writing offset 2 clears every latch bit that is 1 in the write data. Bits written as 0 keep their value. A set write and a clear write on two consecutive cycles both take effect, in that order.
- R4: A write to offset 0 loads the latch with the write data in data-only mode and in set/clear mode. In single-output mode the write is ignored.
- R5: In single-output mode, a write to offset 1 loads the latch with the write data, so 1 drives high and 0 drives low. A read of offset 1 returns the latch.
- R6: In set/clear mode, reads of offset 1 and of offset 2 both return the current output latch.
- R7: With the 1-means-output polarity, pin_oe follows the direction bits. With the 1-means-input polarity, pin_oe is their inverse. Without a direction register, pin_oe is all ones.
- R8: With reversed numbering, pin n maps to register bit WIDTH-1-n for the latch, the direction register and the data read. Otherwise pin n maps to bit n.
- R9: Offsets 4 to 7 read as zero and writes to them are ignored. The same applies to offsets 1 and 2 in data-only mode, offset 2 in single-output mode, and offset 3 when there is no direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pin_in | input | WIDTH | Pin levels from the pads, asynchronous |
| pin_out | output | WIDTH | Pin drive levels |
| pin_oe | output | WIDTH | Per-pin output enable, 1 drives the pad |

## Verification
The bench uses three instances, each with a different combination of latch mode, direction polarity and bit numbering.

- **Set/clear behaviour:** bit patterns that partly overlap the current latch show that only the bits written as 1 change. A set followed by a clear on the very next cycle shows that neither write is lost.
- **Bit numbering:** asymmetric values such as 0x01, 0x03 and 0xC1 tell normal numbering apart from reversed numbering, and tell the two direction polarities apart, at pin_out, at pin_oe and in the data read.
- **Synchronizer latency:** reading the pins one cycle and then two cycles after they change separates a correct two-stage synchronizer from a shorter or longer one.
- **Unmapped and absent registers:** writes of all ones to unmapped offsets, and to registers the mode lacks, show whether any of them reaches the latch or the direction register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // latch write modes
    localparam int OUT_DATA_ONLY = 0;
    localparam int OUT_SET_CLR   = 1;
    localparam int OUT_SET_ONLY  = 2;

    // register word offsets
    localparam int REG_DATA = 0;
    localparam int REG_SET  = 1;
    localparam int REG_CLR  = 2;
    localparam int REG_DIR  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.s2;
endmodule

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
    parameter int WIDTH   = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (REVERSE) begin : g_rev
            assign dst[i] = src[WIDTH-1-i];
        end else begin : g_fwd
            assign dst[i] = src[i];
        end
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 3,
    parameter int OUT_MODE    = OUT_SET_CLR,
    parameter bit HAS_DIR_OUT = 1'b1,
    parameter bit HAS_DIR_IN  = 1'b0,
    parameter bit BIG_END     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    localparam bit DIR_PRESENT = HAS_DIR_OUT || HAS_DIR_IN;
    localparam bit SET_MAPPED  = (OUT_MODE != OUT_DATA_ONLY);
    localparam bit CLR_MAPPED  = (OUT_MODE == OUT_SET_CLR);
    localparam bit DATA_WR_OK  = (OUT_MODE != OUT_SET_ONLY);
    localparam logic [WIDTH-1:0] DIR_RST = HAS_DIR_IN ? '1 : '0;

    // build-time legality
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
        $error("gpio_regbank: WIDTH must be 8, 16, 32 or 64");
    end
    if (HAS_DIR_OUT && HAS_DIR_IN) begin : g_bad_dir
        $error("gpio_regbank: only one direction polarity may be selected");
    end
    if (OUT_MODE < OUT_DATA_ONLY || OUT_MODE > OUT_SET_ONLY) begin : g_bad_mode
        $error("gpio_regbank: OUT_MODE out of range");
    end

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] pin_sync;   // pin order
    logic [WIDTH-1:0] pin_sync_r; // register order
    logic [WIDTH-1:0] oe_r;       // register order

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIG_END)) u_map_in (
        .src (pin_sync),
        .dst (pin_sync_r)
    );

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIG_END)) u_map_out (
        .src (st_q.latch),
        .dst (pin_out)
    );

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(BIG_END)) u_map_oe (
        .src (oe_r),
        .dst (pin_oe)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(REG_DATA): begin
                    if (DATA_WR_OK) st_d.latch = bus_wdata;
                end
                ADDR_W'(REG_SET): begin
                    if (OUT_MODE == OUT_SET_CLR)
                        st_d.latch = st_q.latch | bus_wdata;
                    else if (OUT_MODE == OUT_SET_ONLY)
                        st_d.latch = bus_wdata;
                end
                ADDR_W'(REG_CLR): begin
                    if (CLR_MAPPED) st_d.latch = st_q.latch & ~bus_wdata;
                end
                ADDR_W'(REG_DIR): begin
                    if (DIR_PRESENT) st_d.dir = bus_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '0;
            st_q.dir   <= DIR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // output enable in register order
    always_comb begin
        if (HAS_DIR_OUT)     oe_r = st_q.dir;
        else if (HAS_DIR_IN) oe_r = ~st_q.dir;
        else                 oe_r = '1;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_DATA): bus_rdata = pin_sync_r;
            ADDR_W'(REG_SET):  if (SET_MAPPED)  bus_rdata = st_q.latch;
            ADDR_W'(REG_CLR):  if (CLR_MAPPED)  bus_rdata = st_q.latch;
            ADDR_W'(REG_DIR):  if (DIR_PRESENT) bus_rdata = st_q.dir;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 3,
    parameter int OUT_MODE    = OUT_SET_CLR,
    parameter bit HAS_DIR_OUT = 1'b1,
    parameter bit HAS_DIR_IN  = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  latch,
    input logic [WIDTH-1:0]  dir
);
    localparam bit SET_CLR  = (OUT_MODE == OUT_SET_CLR);
    localparam bit SET_ONLY = (OUT_MODE == OUT_SET_ONLY);

    logic unmapped;
    assign unmapped = int'(bus_addr) > REG_DIR;

    // R3: set write raises the written ones and keeps the rest
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (SET_CLR && bus_wr && bus_addr == ADDR_W'(REG_SET)) |=>
        (((latch & $past(bus_wdata)) == $past(bus_wdata)) &&
         ((latch & ~$past(bus_wdata)) == ($past(latch) & ~$past(bus_wdata)))))
        else $error("p_set_r3");

    // R3: clear write drops the written ones and keeps the rest
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (SET_CLR && bus_wr && bus_addr == ADDR_W'(REG_CLR)) |=>
        (((latch & $past(bus_wdata)) == '0) &&
         ((latch & ~$past(bus_wdata)) == ($past(latch) & ~$past(bus_wdata)))))
        else $error("p_clr_r3");

    // R5: plain output register loads the latch
    p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (SET_ONLY && bus_wr && bus_addr == ADDR_W'(REG_SET)) |=>
        (latch == $past(bus_wdata)))
        else $error("p_single_load_r5");

    // R4: data write ignored in single-output mode
    p_data_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (SET_ONLY && bus_wr && bus_addr == ADDR_W'(REG_DATA)) |=> $stable(latch))
        else $error("p_data_ignored_r4");

    // R9: unmapped writes change nothing
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=> ($stable(latch) && $stable(dir)))
        else $error("p_unmapped_wr_r9");

    // R9: unmapped reads return zero
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0))
        else $error("p_unmapped_rd_r9");

    // R1: state moves only on a bus write
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(latch) && $stable(dir)))
        else $error("p_idle_hold_r1");

    // R7: direction register fixed without one present
    p_nodir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(HAS_DIR_OUT || HAS_DIR_IN) && bus_wr) |=> $stable(dir))
        else $error("p_nodir_r7");
endmodule

bind gpio_regbank gpio_regbank_chk #(
    .WIDTH       (WIDTH),
    .ADDR_W      (ADDR_W),
    .OUT_MODE    (OUT_MODE),
    .HAS_DIR_OUT (HAS_DIR_OUT),
    .HAS_DIR_IN  (HAS_DIR_IN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .latch     (st_q.latch),
    .dir       (st_q.dir)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;
    import gpio_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]      wr    = '0;
    logic [2:0][2:0] addr  = '0;
    logic [2:0][7:0] wdata = '0;
    logic [2:0][7:0] rdata;
    logic [2:0][7:0] pout;
    logic [2:0][7:0] poe;
    logic [7:0]      pin   = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // u0: set/clear, 1 = output, normal numbering
    gpio_regbank #(.WIDTH(8), .OUT_MODE(OUT_SET_CLR), .HAS_DIR_OUT(1'b1),
                   .HAS_DIR_IN(1'b0), .BIG_END(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr[0]), .bus_addr(addr[0]),
        .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .pin_in(pin),
        .pin_out(pout[0]), .pin_oe(poe[0]));

    // u1: single output register, 1 = input, reversed numbering
    gpio_regbank #(.WIDTH(8), .OUT_MODE(OUT_SET_ONLY), .HAS_DIR_OUT(1'b0),
                   .HAS_DIR_IN(1'b1), .BIG_END(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr[1]), .bus_addr(addr[1]),
        .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .pin_in(pin),
        .pin_out(pout[1]), .pin_oe(poe[1]));

    // u2: data register only, no direction register
    gpio_regbank #(.WIDTH(8), .OUT_MODE(OUT_DATA_ONLY), .HAS_DIR_OUT(1'b0),
                   .HAS_DIR_IN(1'b0), .BIG_END(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr[2]), .bus_addr(addr[2]),
        .bus_wdata(wdata[2]), .bus_rdata(rdata[2]), .pin_in(pin),
        .pin_out(pout[2]), .pin_oe(poe[2]));

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int u, int a, logic [7:0] d);
        @(negedge clk);
        wr[u] = 1'b1; addr[u] = 3'(a); wdata[u] = d;
        @(negedge clk);
        wr[u] = 1'b0;
    endtask

    task automatic rd_reg(int u, int a, output logic [7:0] v);
        @(negedge clk);
        addr[u] = 3'(a);
        #1 v = rdata[u];
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 u0 pin_out", pout[0], 8'h00);
        chk("R1 u0 pin_oe", poe[0], 8'h00);
        rd_reg(0, REG_DIR, v); chk("R1 u0 dir", v, 8'h00);
        chk("R1 u1 pin_oe", poe[1], 8'h00);
        rd_reg(1, REG_DIR, v); chk("R1 u1 dir", v, 8'hFF);
        chk("R7 u2 pin_oe all ones", poe[2], 8'hFF);
    endtask

    task automatic t_setclr();
        logic [7:0] v;
        wr_reg(0, REG_SET, 8'h05); chk("R3 set 05", pout[0], 8'h05);
        wr_reg(0, REG_SET, 8'h30); chk("R3 set 30", pout[0], 8'h35);
        wr_reg(0, REG_CLR, 8'h01); chk("R3 clr 01", pout[0], 8'h34);
        // back-to-back set then clear
        @(negedge clk);
        wr[0] = 1'b1; addr[0] = 3'(REG_SET); wdata[0] = 8'h80;
        @(negedge clk);
        addr[0] = 3'(REG_CLR); wdata[0] = 8'h04;
        @(negedge clk);
        wr[0] = 1'b0;
        chk("R3 consecutive set/clr", pout[0], 8'hB0);
        rd_reg(0, REG_SET, v); chk("R6 read set", v, 8'hB0);
        rd_reg(0, REG_CLR, v); chk("R6 read clr", v, 8'hB0);
        wr_reg(0, REG_DATA, 8'h5A); chk("R4 u0 data write", pout[0], 8'h5A);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr_reg(0, 6, 8'hFF);
        chk("R9 u0 write addr6 latch", pout[0], 8'h5A);
        chk("R9 u0 write addr6 oe", poe[0], 8'h00);
        rd_reg(0, 5, v); chk("R9 u0 read addr5", v, 8'h00);
        rd_reg(0, 7, v); chk("R9 u0 read addr7", v, 8'h00);
        rd_reg(0, REG_DIR, v); chk("R9 u0 dir after addr6 write", v, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        wr_reg(0, REG_DIR, 8'h0F); chk("R7 u0 oe", poe[0], 8'h0F);
        rd_reg(0, REG_DIR, v); chk("R7 u0 dir read", v, 8'h0F);
        wr_reg(1, REG_DIR, 8'h03); chk("R7 R8 u1 inverted oe", poe[1], 8'h3F);
    endtask

    task automatic t_single();
        logic [7:0] v;
        wr_reg(1, REG_SET, 8'h01); chk("R5 R8 u1 pin_out", pout[1], 8'h80);
        rd_reg(1, REG_SET, v); chk("R5 u1 read set", v, 8'h01);
        wr_reg(1, REG_SET, 8'h02); chk("R5 u1 zero drives low", pout[1], 8'h40);
        wr_reg(1, REG_DATA, 8'hFF); chk("R4 u1 data write ignored", pout[1], 8'h40);
        rd_reg(1, REG_CLR, v); chk("R9 u1 clr unmapped", v, 8'h00);
    endtask

    task automatic t_dataonly();
        logic [7:0] v;
        rd_reg(2, REG_DIR, v); chk("R9 u2 dir unmapped", v, 8'h00);
        wr_reg(2, REG_DATA, 8'h3C); chk("R4 u2 data write", pout[2], 8'h3C);
        wr_reg(2, REG_SET, 8'hFF); chk("R9 u2 set write ignored", pout[2], 8'h3C);
        wr_reg(2, REG_CLR, 8'hFF); chk("R9 u2 clr write ignored", pout[2], 8'h3C);
        rd_reg(2, REG_SET, v); chk("R9 u2 set unmapped", v, 8'h00);
        chk("R7 u2 oe after writes", poe[2], 8'hFF);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        addr[0] = 3'(REG_DATA); addr[1] = 3'(REG_DATA);
        @(negedge clk);
        pin = 8'hC1;
        @(negedge clk);
        #1 v = rdata[0]; chk("R2 one edge not yet", v, 8'h00);
        @(negedge clk);
        #1 v = rdata[0]; chk("R2 two edges", v, 8'hC1);
        v = rdata[1]; chk("R2 R8 u1 reversed read", v, rev8(8'hC1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setclr();
        t_unmapped();
        t_dir();
        t_single();
        t_dataonly();
        t_sync();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule